// File: doc/BRIEF.md
# Five-Channel Timer with Infrared Carrier Gating

This block is a 16-bit timer whose counter runs from zero up to a programmable period value and then returns to zero. The counter steps on a divided version of the system clock. Five channels observe the counter. Each channel either drives a pulse-width output or records the counter value when its input pin changes. Software programs the block through a simple register-write port. Capture results and flags appear on output ports.

For infrared remote-control signals, an IR mode changes two things. The counter steps once per period event of a separate carrier timer instead of once per divided clock. Each pulse-width output is also ANDed with that carrier timer's output. The result is a modulated burst pattern that needs no processor work per pulse. The carrier timer is outside the block and arrives as two inputs: its output level and a one-cycle tick at the end of each of its periods.

New compare values are held in a shadow register. While the counter runs, a new value reaches the comparator only when the counter wraps, so an output never sees a half-finished period.

Top module: `irtmr_top`

## Requirements
- R1: When the counter advances, it goes from C to C+1 if C is below the period value, and it returns to 0 if C is at or above the period value. The period value resets to 0xFFFF.
- R2: When the block runs and IR mode is off, the counter advances once every 1, 8, 32 or 128 clocks. The divider field selects the rate: 0 gives 1, 1 gives 8, 2 gives 32 and 3 gives 128.
- R3: When the run bit is 0, the counter holds its value and the clock divider returns to its starting phase. After the run bit is set again, the first advance comes a full divide interval later.
- R4: In compare mode, a channel's pulse-width level is updated on each counter advance. It goes low when the new count equals the channel's compare value. It goes high when the new count is 0, unless the compare value is also 0. A compare value of 0 therefore keeps the output low.
- R5: In IR mode, the counter advances on a clock where carrier_tick is 1, and only on such a clock. The divider has no effect.
- R6: In IR mode, each compare-mode channel output equals its pulse-width level ANDed with carrier_in.
- R7: In capture mode, the channel output is 0. On a selected edge of cap_in[i], the counter value from before that clock edge is copied into cap_val[16*i+15:16*i]. An edge is seen when the input differs from its value on the previous clock. The two edge-enable bits in the channel configuration choose the edges: rising only, falling only or both.
- R8: A capture sets cap_flag[i]. irq is the OR of all flags. Writing a 1 to bit i at the flag-clear address clears flag i. If a capture and a clear land on the same clock, the capture wins.
- R9: A written compare value reaches the comparator on the next counter wrap while the block runs. While the block is stopped, it reaches the comparator one clock after the write.
- R10: Register map at wr_addr:
  - Address 0 is control: bit0 is run, bits 2:1 are the divider and bit3 is IR mode.
  - Address 1 is the period.
  - Address 2 is flag clear: bit i clears flag i.
  - Addresses 3 to 7 hold the configuration of channels 0 to 4: bit0 is capture mode, bit1 enables rising edges and bit2 enables falling edges.
  - Addresses 8 to 12 hold the compare values of channels 0 to 4.
  - All registers and outputs reset to 0, except the period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 16 | Register write data |
| cap_in | input | 5 | Capture input pins, one per channel |
| carrier_in | input | 1 | Output level of the external carrier timer |
| carrier_tick | input | 1 | One-cycle period event of the carrier timer |
| cnt_out | output | 16 | Current counter value |
| ch_out | output | 5 | Channel outputs |
| cap_val | output | 80 | Captured counter values, 16 bits per channel |
| cap_flag | output | 5 | Per-channel capture flags |
| irq | output | 1 | Interrupt, OR of the capture flags |

## Verification
On every cycle, the assertions check four things:
- the counter's step and hold rules, including the hold on clocks without a carrier tick in IR mode;
- that the active compare value stays fixed between wraps while the block runs;
- that a compare value of 0 keeps the output low;
- that flags and captured values change only on channels in capture mode.

Only the bench scenarios can show the rest. These are the exact divide intervals, the output pulse widths, delayed compare loading, capture of the pre-edge count under each edge selection, and the clear-versus-capture race. They are shown by comparing every output against the reference model on each clock.

// File: rtl/irtmr_pkg.sv
package irtmr_pkg;

    localparam int CNT_W    = 16;
    localparam int N_CH     = 5;
    localparam int ADDR_W   = 4;
    localparam int PRE_W    = 7;

    localparam int A_CTRL    = 0;
    localparam int A_PERIOD  = 1;
    localparam int A_FLAGCLR = 2;
    localparam int A_CFG0    = 3;
    localparam int A_CMP0    = 8;

    typedef enum logic [1:0] {
        DIV1   = 2'd0,
        DIV8   = 2'd1,
        DIV32  = 2'd2,
        DIV128 = 2'd3
    } div_e;

    typedef struct packed {
        logic ir_mode;
        div_e div_sel;
        logic run;
    } ctrl_t;

    typedef struct packed {
        logic fall_en;
        logic rise_en;
        logic cap_mode;
    } chcfg_t;

    function automatic logic [PRE_W-1:0] pre_limit(input div_e sel);
        case (sel)
            DIV1:    return PRE_W'(0);
            DIV8:    return PRE_W'(7);
            DIV32:   return PRE_W'(31);
            default: return PRE_W'(127);
        endcase
    endfunction

endpackage

// File: rtl/irtmr_prescale.sv
module irtmr_prescale
    import irtmr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  ctrl_t ctrl,
    input  logic  carrier_tick,
    output logic  tick
);
    logic [PRE_W-1:0] pre_q;
    logic             hit;

    assign hit  = (pre_q >= pre_limit(ctrl.div_sel));
    assign tick = ctrl.run && (ctrl.ir_mode ? carrier_tick : hit);

    always_ff @(posedge clk) begin
        if (rst || !ctrl.run)
            pre_q <= '0;
        else if (hit)
            pre_q <= '0;
        else
            pre_q <= pre_q + PRE_W'(1);
    end
endmodule

// File: rtl/irtmr_count.sv
module irtmr_count #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         tick,
    input  logic [W-1:0] period,
    output logic [W-1:0] cnt,
    output logic [W-1:0] nxt,
    output logic         wrap
);
    logic [W-1:0] cnt_q;

    assign wrap = tick && (cnt_q >= period);
    assign nxt  = wrap ? '0 : cnt_q + W'(1);
    assign cnt  = cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= nxt;
    end

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (tick && cnt_q < period) |=> (cnt_q == $past(cnt_q) + W'(1)));

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cnt_q));
endmodule

// File: rtl/irtmr_chan.sv
module irtmr_chan
    import irtmr_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         run,
    input  logic         ir_mode,
    input  logic         tick,
    input  logic         wrap,
    input  logic [W-1:0] cnt,
    input  logic [W-1:0] nxt,
    input  chcfg_t       cfg,
    input  logic [W-1:0] shadow,
    input  logic         carrier_in,
    input  logic         cap_in,
    input  logic         flag_clr,
    output logic         ch_out,
    output logic [W-1:0] cap_val,
    output logic         flag
);
    logic [W-1:0] act_q;
    logic [W-1:0] cmp_eff;
    logic [W-1:0] cap_q;
    logic         pwm_q;
    logic         prev_q;
    logic         flag_q;
    logic         rise;
    logic         fall;
    logic         hit;

    assign cmp_eff = wrap ? shadow : act_q;
    assign rise    = cap_in && !prev_q;
    assign fall    = !cap_in && prev_q;
    assign hit     = cfg.cap_mode && ((cfg.rise_en && rise) || (cfg.fall_en && fall));

    always_ff @(posedge clk) begin
        if (rst) begin
            act_q  <= '0;
            pwm_q  <= 1'b0;
            prev_q <= 1'b0;
            cap_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (!run || wrap)
                act_q <= shadow;
            if (tick) begin
                if (nxt == cmp_eff)
                    pwm_q <= 1'b0;
                else if (nxt == '0)
                    pwm_q <= 1'b1;
            end
            prev_q <= cap_in;
            if (hit) begin
                cap_q  <= cnt;
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

    assign ch_out  = cfg.cap_mode ? 1'b0 : (ir_mode ? (pwm_q & carrier_in) : pwm_q);
    assign cap_val = cap_q;
    assign flag    = flag_q;

    p_cmp_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (run && !wrap) |=> $stable(act_q));

    p_zero_cmp_r4: assert property (@(posedge clk) disable iff (rst)
        (tick && act_q == '0 && shadow == '0) |=> !pwm_q);

    p_capflag_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_q) |-> $past(cfg.cap_mode));

    p_capval_r7: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_q) |-> $past(cfg.cap_mode));
endmodule

// File: rtl/irtmr_top.sv
module irtmr_top
    import irtmr_pkg::*;
#(
    parameter int N     = N_CH,
    parameter int W     = CNT_W,
    parameter int AW    = ADDR_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [W-1:0]   wr_data,
    input  logic [N-1:0]   cap_in,
    input  logic           carrier_in,
    input  logic           carrier_tick,
    output logic [W-1:0]   cnt_out,
    output logic [N-1:0]   ch_out,
    output logic [N*W-1:0] cap_val,
    output logic [N-1:0]   cap_flag,
    output logic           irq
);
    ctrl_t        ctrl_q;
    logic [W-1:0] period_q;
    chcfg_t       cfg_q    [N];
    logic [W-1:0] shadow_q [N];
    logic [N-1:0] clr;
    logic         tick;
    logic         wrap;
    logic [W-1:0] cnt;
    logic [W-1:0] nxt;

    assign clr = (wr_en && wr_addr == AW'(A_FLAGCLR)) ? wr_data[N-1:0] : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q   <= '0;
            period_q <= '1;
            for (int i = 0; i < N; i++) begin
                cfg_q[i]    <= '0;
                shadow_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (wr_addr == AW'(A_CTRL))
                ctrl_q <= ctrl_t'(wr_data[3:0]);
            if (wr_addr == AW'(A_PERIOD))
                period_q <= wr_data;
            for (int i = 0; i < N; i++) begin
                if (wr_addr == AW'(A_CFG0 + i))
                    cfg_q[i] <= chcfg_t'(wr_data[2:0]);
                if (wr_addr == AW'(A_CMP0 + i))
                    shadow_q[i] <= wr_data;
            end
        end
    end

    irtmr_prescale u_pre (
        .clk          (clk),
        .rst          (rst),
        .ctrl         (ctrl_q),
        .carrier_tick (carrier_tick),
        .tick         (tick)
    );

    irtmr_count #(.W(W)) u_cnt (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .period (period_q),
        .cnt    (cnt),
        .nxt    (nxt),
        .wrap   (wrap)
    );

    for (genvar g = 0; g < N; g++) begin : g_ch
        irtmr_chan #(.W(W)) u_ch (
            .clk        (clk),
            .rst        (rst),
            .run        (ctrl_q.run),
            .ir_mode    (ctrl_q.ir_mode),
            .tick       (tick),
            .wrap       (wrap),
            .cnt        (cnt),
            .nxt        (nxt),
            .cfg        (cfg_q[g]),
            .shadow     (shadow_q[g]),
            .carrier_in (carrier_in),
            .cap_in     (cap_in[g]),
            .flag_clr   (clr[g]),
            .ch_out     (ch_out[g]),
            .cap_val    (cap_val[g*W +: W]),
            .flag       (cap_flag[g])
        );
    end

    assign cnt_out = cnt;
    assign irq     = |cap_flag;

    p_ir_tick_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.run && ctrl_q.ir_mode && !carrier_tick) |=> $stable(cnt_out));
endmodule

// File: tb/test_irtmr_top.sv
`timescale 1ns/1ps
module test_irtmr_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [4:0]  cap_in = '0;
    logic        carrier_in = 1'b0;
    logic        carrier_tick = 1'b0;
    logic [15:0] cnt_out;
    logic [4:0]  ch_out;
    logic [79:0] cap_val;
    logic [4:0]  cap_flag;
    logic        irq;

    always #2 clk = ~clk;

    irtmr_top i_irtmr_top (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .cap_in(cap_in), .carrier_in(carrier_in), .carrier_tick(carrier_tick),
        .cnt_out(cnt_out), .ch_out(ch_out), .cap_val(cap_val),
        .cap_flag(cap_flag), .irq(irq)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    seen_edge = 0;
    bit    done = 0;
    string phase = "R10";

    // reference model state
    bit [15:0] m_cnt, m_period, m_sh[5], m_act[5], m_cap[5];
    bit        m_run, m_ir, m_pwm[5], m_prev[5], m_flag[5];
    bit [2:0]  m_cfg[5];
    int        m_div, m_pre;

    task automatic chk(string sig, logic [15:0] act, logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: act=%h exp=%h at %0t", phase, sig, act, exp, $time);
        end
    endtask

    function automatic int div_limit(int sel);
        if (sel == 0) return 0;
        if (sel == 1) return 7;
        if (sel == 2) return 31;
        return 127;
    endfunction

    always @(posedge clk) begin
        seen_edge <= 1'b1;
        if (rst) begin
            m_cnt = 0; m_period = 16'hFFFF; m_run = 0; m_ir = 0; m_div = 0; m_pre = 0;
            for (int i = 0; i < 5; i++) begin
                m_sh[i] = 0; m_act[i] = 0; m_cap[i] = 0; m_pwm[i] = 0;
                m_prev[i] = 0; m_flag[i] = 0; m_cfg[i] = 0;
            end
        end else begin
            bit        tk, wr;
            bit [15:0] nx, ce;
            int        lim;
            lim = div_limit(m_div);
            tk  = m_run && (m_ir ? carrier_tick : (m_pre >= lim));
            wr  = tk && (m_cnt >= m_period);
            nx  = wr ? 16'd0 : (tk ? m_cnt + 16'd1 : m_cnt);
            for (int i = 0; i < 5; i++) begin
                bit rs, fl, hit;
                ce = wr ? m_sh[i] : m_act[i];
                if (tk) begin
                    if (nx == ce) m_pwm[i] = 0;
                    else if (nx == 0) m_pwm[i] = 1;
                end
                if (!m_run || wr) m_act[i] = m_sh[i];
                rs  = cap_in[i] && !m_prev[i];
                fl  = !cap_in[i] && m_prev[i];
                hit = m_cfg[i][0] && ((m_cfg[i][1] && rs) || (m_cfg[i][2] && fl));
                if (hit) begin
                    m_cap[i] = m_cnt; m_flag[i] = 1;
                end else if (wr_en && wr_addr == 2 && wr_data[i]) begin
                    m_flag[i] = 0;
                end
                m_prev[i] = cap_in[i];
            end
            m_pre = !m_run ? 0 : ((m_pre >= lim) ? 0 : m_pre + 1);
            m_cnt = nx;
            if (wr_en) begin
                if (wr_addr == 0) begin
                    m_run = wr_data[0]; m_div = int'(wr_data[2:1]); m_ir = wr_data[3];
                end
                if (wr_addr == 1) m_period = wr_data;
                if (wr_addr >= 3 && wr_addr <= 7) m_cfg[wr_addr-3] = wr_data[2:0];
                if (wr_addr >= 8 && wr_addr <= 12) m_sh[wr_addr-8] = wr_data;
            end
        end
    end

    always @(negedge clk) begin
        if (seen_edge && !done) begin
            logic [4:0] e_out, e_flag;
            for (int i = 0; i < 5; i++) begin
                e_out[i]  = m_cfg[i][0] ? 1'b0 : (m_ir ? (m_pwm[i] & carrier_in) : m_pwm[i]);
                e_flag[i] = m_flag[i];
                chk($sformatf("cap_val[%0d]", i), cap_val[i*16 +: 16], m_cap[i]);
            end
            chk("cnt_out", cnt_out, m_cnt);
            chk("ch_out", {11'd0, ch_out}, {11'd0, e_out});
            chk("cap_flag", {11'd0, cap_flag}, {11'd0, e_flag});
            chk("irq", {15'd0, irq}, {15'd0, |e_flag});
        end
    end

    // external carrier: 5-cycle period, high 3 cycles, tick on the last one
    int car_ph = 0;
    always @(negedge clk) begin
        #1;
        car_ph     = (car_ph + 1) % 5;
        carrier_in   = (car_ph < 3);
        carrier_tick = (car_ph == 4);
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wreg(int a, int d);
        @(negedge clk); #1;
        wr_en = 1; wr_addr = 4'(a); wr_data = 16'(d);
        @(negedge clk); #1;
        wr_en = 0;
    endtask

    task automatic pin(int ch, bit v);
        @(negedge clk); #1;
        cap_in[ch] = v;
    endtask

    initial begin
        idle(3);
        @(negedge clk); #1 rst = 0;
        phase = "R10";
        idle(1);
        chk("reset cnt_out", cnt_out, 16'd0);
        chk("reset irq", {15'd0, irq}, 16'd0);

        phase = "R1";
        wreg(1, 9);
        wreg(8, 4); wreg(9, 0); wreg(10, 20); wreg(11, 9);
        phase = "R4";
        wreg(0, 16'h1);
        idle(45);

        phase = "R9";
        idle(3);
        wreg(8, 7);
        idle(30);

        phase = "R2";
        wreg(0, 16'h3); idle(200);
        wreg(0, 16'h5); idle(400);
        wreg(1, 2);
        wreg(0, 16'h7); idle(900);
        wreg(1, 9);
        wreg(0, 16'h1); idle(20);

        phase = "R3";
        wreg(0, 16'h2); idle(10);
        wreg(8, 2); idle(5);
        wreg(0, 16'h3); idle(60);
        wreg(0, 16'h1);

        phase = "R7";
        wreg(6, 3); wreg(7, 7); wreg(5, 5);
        pin(4, 1); idle(4);
        pin(3, 1); pin(2, 1); idle(6);
        pin(3, 0); pin(2, 0); idle(3);
        pin(4, 0); pin(1, 1); idle(7);
        pin(1, 0); idle(3);

        phase = "R8";
        wreg(2, 16'h1F); idle(3);
        @(negedge clk); #1 cap_in[3] = 0;
        @(negedge clk); #1;
        cap_in[3] = 1; wr_en = 1; wr_addr = 4'd2; wr_data = 16'h08;
        @(negedge clk); #1 wr_en = 0;
        idle(3);
        wreg(2, 16'h1F); idle(3);

        phase = "R5";
        wreg(3, 0); wreg(4, 0);
        wreg(1, 5); wreg(8, 3); wreg(9, 4);
        wreg(0, 16'h9);
        phase = "R6";
        idle(250);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            done = 1;
            n_bad++;
            $display("FAIL R1 watchdog: act=running exp=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule